// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Converter

This block turns a phase index that spans one full cycle into a signed sine sample. It stores only the first quarter of the waveform. The two most significant bits of the phase name the quadrant. The remaining bits address the stored quarter: the falling quadrants read it in reverse order, and the lower half-cycle returns the negated value. A phase accumulator that sits upstream feeds it one index per cycle, and a mixer or DAC path downstream takes the registered sample.

The quarter table holds samples at integer steps of a quarter period divided by 2^(PHASE_W-2), scaled to a full scale of 2^(AMP_W-1)-1. Its contents are computed during elaboration. The peak value sits one step past the last stored entry. When a mirrored address wraps to zero, the block substitutes the full-scale constant instead of storing an extra row.

Top module: `qw_sine_lut`

## Requirements
- R1: Phase index 0 produces a sample of exactly 0.
- R2: For phase p in the first quadrant (p < 2^(PHASE_W-2)), the sample equals round(F·sin(2πp/2^PHASE_W)) within ±1, where F = 2^(AMP_W-1)-1 and rounding is half away from zero.
- R3: In the second quadrant (top two phase bits = 01), the sample matches the same full-cycle reference within ±1. This quadrant reads the table at the mirrored index 2^(PHASE_W-2) minus the low bits.
- R4: In the third quadrant (top bits = 10), the sample is the negated table value at the direct index and matches the reference within ±1.
- R5: In the fourth quadrant (top bits = 11), the sample is the negated table value at the mirrored index and matches the reference within ±1.
- R6: The quarter-cycle phase 2^(PHASE_W-2) gives exactly +F. The three-quarter phase 3·2^(PHASE_W-2) gives exactly -F.
- R7: The half-cycle phase 2^(PHASE_W-1) gives exactly 0.
- R8: out_valid and sample follow an in_valid input after exactly one rising clock edge, and out_valid is low in the cycle after in_valid is low.
- R9: While rst_n is low, out_valid and sample are 0, whatever in_valid and phase carry.
- R10: While in_valid is low, sample holds its last value, and phase changes have no effect on it.
- R11: When the phase MSB is 0 the sample is non-negative, and when it is 1 the sample is non-positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phase index is valid this cycle |
| phase | input | PHASE_W | Full-cycle phase index (0 to 2^PHASE_W-1) |
| out_valid | output | 1 | sample carries a new result |
| sample | output | AMP_W | Signed two's-complement sine amplitude |

## Verification
The embedded properties check the following on every cycle:
- the one-edge valid latency;
- that the sample holds while no request is presented;
- the sign of each half-cycle;
- the exact values at the four cardinal phases (0, quarter, half, three-quarter).

Only the bench's full sweep of every phase index against a reference computed over the whole cycle shows that each quadrant rebuilds the right amplitude. That sweep checks the mirrored addressing and the substituted peak. The bench also shows that reset forces the outputs to zero while stimulus is applied.

// File: rtl/qw_sine_pkg.sv
`timescale 1ns/1ps
package qw_sine_pkg;

   typedef enum logic [1:0] {
      QD_RISE    = 2'd0,
      QD_FALL    = 2'd1,
      QD_DIP     = 2'd2,
      QD_RECOVER = 2'd3
   } quad_e;

   localparam real QW_HALF_PI = 1.5707963267948966;

   // magnitude of quarter-table row k, idx_w address bits, amp_w signed output bits
   function automatic int qw_entry(input int k, input int idx_w, input int amp_w);
      real step;
      real full;
      real val;
      step = QW_HALF_PI / (2.0 ** idx_w);
      full = (2.0 ** (amp_w - 1)) - 1.0;
      val  = full * $sin(step * k);
      return $rtoi(val + 0.5);
   endfunction

endpackage

// File: rtl/qw_quadrant_decode.sv
`timescale 1ns/1ps
module qw_quadrant_decode
   import qw_sine_pkg::*;
#(
   parameter int PHASE_W = 11
) (
   input  logic [PHASE_W-1:0] phase,
   output logic [PHASE_W-3:0] addr,
   output logic               peak,
   output logic               neg
);
   localparam int IDX_W = PHASE_W - 2;

   quad_e            quad;
   logic [IDX_W-1:0] resid;
   logic [IDX_W-1:0] resid_mir;
   logic             mirror;

   assign quad      = quad_e'(phase[PHASE_W-1 -: 2]);
   assign resid     = phase[IDX_W-1:0];
   assign resid_mir = ~resid + {{(IDX_W-1){1'b0}}, 1'b1};

   always_comb begin
      unique case (quad)
         QD_RISE:    begin mirror = 1'b0; neg = 1'b0; end
         QD_FALL:    begin mirror = 1'b1; neg = 1'b0; end
         QD_DIP:     begin mirror = 1'b0; neg = 1'b1; end
         QD_RECOVER: begin mirror = 1'b1; neg = 1'b1; end
         default:    begin mirror = 1'b0; neg = 1'b0; end
      endcase
   end

   assign addr = mirror ? resid_mir : resid;
   assign peak = mirror && (resid == '0);

endmodule

// File: rtl/qw_quarter_rom.sv
`timescale 1ns/1ps
module qw_quarter_rom
   import qw_sine_pkg::*;
#(
   parameter int IDX_W = 9,
   parameter int AMP_W = 16
) (
   input  logic [IDX_W-1:0] addr,
   output logic [AMP_W-2:0] mag
);
   localparam int MAG_W = AMP_W - 1;
   localparam int ROWS  = 1 << IDX_W;

   logic [MAG_W-1:0] tbl [ROWS];

   for (genvar k = 0; k < ROWS; k++) begin : g_row
      assign tbl[k] = MAG_W'(qw_entry(k, IDX_W, AMP_W));
   end

   assign mag = tbl[addr];

endmodule

// File: rtl/qw_output_stage.sv
`timescale 1ns/1ps
module qw_output_stage #(
   parameter int AMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [AMP_W-2:0] mag,
   input  logic             peak,
   input  logic             neg,
   output logic             out_valid,
   output logic [AMP_W-1:0] sample
);
   localparam int MAG_W = AMP_W - 1;
   localparam logic [MAG_W-1:0] FULL = {MAG_W{1'b1}};

   logic [AMP_W-1:0] pos_val;
   logic [AMP_W-1:0] next_val;

   assign pos_val  = {1'b0, (peak ? FULL : mag)};
   assign next_val = neg ? (~pos_val + {{(AMP_W-1){1'b0}}, 1'b1}) : pos_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         sample    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) sample <= next_val;
      end
   end

   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sample));

endmodule

// File: rtl/qw_sine_lut.sv
`timescale 1ns/1ps
module qw_sine_lut #(
   parameter int PHASE_W = 11,
   parameter int AMP_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PHASE_W-1:0] phase,
   output logic               out_valid,
   output logic [AMP_W-1:0]   sample
);
   localparam int IDX_W = PHASE_W - 2;
   localparam logic [PHASE_W-1:0] PH_QTR  = PHASE_W'(1) << IDX_W;
   localparam logic [PHASE_W-1:0] PH_HALF = PHASE_W'(2) << IDX_W;
   localparam logic [PHASE_W-1:0] PH_3QTR = PHASE_W'(3) << IDX_W;
   localparam logic signed [AMP_W-1:0] AMP_FULL = AMP_W'((1 << (AMP_W - 1)) - 1);

   if (PHASE_W < 4 || PHASE_W > 14) begin : g_bad_phase_w
      $error("qw_sine_lut: PHASE_W must lie in 4..14");
   end
   if (AMP_W < 4 || AMP_W > 30) begin : g_bad_amp_w
      $error("qw_sine_lut: AMP_W must lie in 4..30");
   end

   logic [IDX_W-1:0] addr;
   logic             peak;
   logic             neg;
   logic [AMP_W-2:0] mag;

   qw_quadrant_decode #(.PHASE_W(PHASE_W)) u_decode (
      .phase (phase),
      .addr  (addr),
      .peak  (peak),
      .neg   (neg)
   );

   qw_quarter_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_rom (
      .addr (addr),
      .mag  (mag)
   );

   qw_output_stage #(.AMP_W(AMP_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .mag       (mag),
      .peak      (peak),
      .neg       (neg),
      .out_valid (out_valid),
      .sample    (sample)
   );

   // R1
   zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == '0) |=> (sample == '0));
   // R6
   quarter_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == PH_QTR) |=> ($signed(sample) == AMP_FULL));
   // R6
   trough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == PH_3QTR) |=> ($signed(sample) == -AMP_FULL));
   // R7
   half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase == PH_HALF) |=> (sample == '0));
   // R11
   upper_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !phase[PHASE_W-1]) |=> ($signed(sample) >= 0));
   // R11
   lower_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && phase[PHASE_W-1]) |=> ($signed(sample) <= 0));

endmodule

// File: tb/tb_qw_sine_lut.sv
`timescale 1ns/1ps
module tb_qw_sine_lut;
   localparam int PW   = 11;
   localparam int AW   = 16;
   localparam int NPH  = 1 << PW;
   localparam int QTR  = NPH / 4;
   localparam int FS   = (1 << (AW - 1)) - 1;

   typedef struct {
      int    ph;
      int    exp;
      int    tol;
      int    due;
      string tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [PW-1:0] phase = '0;
   logic          out_valid;
   logic [AW-1:0] sample;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   item_t sb[$];

   qw_sine_lut #(.PHASE_W(PW), .AMP_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase(phase),
      .out_valid(out_valid), .sample(sample)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int ref_amp(input int p);
      real a;
      real s;
      a = 2.0 * 3.14159265358979323846 * p / NPH;
      s = FS * $sin(a);
      if (s >= 0.0) return $rtoi(s + 0.5);
      return -$rtoi(-s + 0.5);
   endfunction

   function automatic string tag_of(input int p);
      if (p == 0) return "R1";
      if (p == QTR || p == 3 * QTR) return "R6";
      if (p == 2 * QTR) return "R7";
      if (p < QTR) return "R2";
      if (p < 2 * QTR) return "R3";
      if (p < 3 * QTR) return "R4";
      return "R5";
   endfunction

   task automatic check(input string tag, input int got, input int exp, input int tol);
      int d;
      n_cmp++;
      d = got - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d (tol %0d)", tag, got, exp, tol);
      end
   endtask

   task automatic send(input int p);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      phase    = PW'(p);
      it.ph  = p;
      it.exp = ref_amp(p);
      it.tol = (p % QTR == 0) ? 0 : 1;
      it.due = cyc + 1;
      it.tag = tag_of(p);
      sb.push_back(it);
   endtask

   task automatic idle(input int p);
      @(negedge clk);
      in_valid = 1'b0;
      phase    = PW'(p);
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (sb.size() == 0 || sb[0].due != cyc) begin
               n_cmp++; n_bad++;
               $display("FAIL R8: unexpected out_valid at cycle %0d got 1 expected 0", cyc);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(it.tag, $signed(sample), it.exp, it.tol);
               // R11 sign per half-cycle
               if (it.ph < NPH / 2) check("R11", ($signed(sample) >= 0) ? 1 : 0, 1, 0);
               else                 check("R11", ($signed(sample) <= 0) ? 1 : 0, 1, 0);
            end
         end else if (sb.size() != 0 && sb[0].due == cyc) begin
            n_cmp++; n_bad++;
            $display("FAIL R8: result for phase %0d missing, got out_valid 0 expected 1", sb[0].ph);
            void'(sb.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] held;
      // R9: stimulus during reset must not reach the outputs
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         phase    = PW'(QTR + i);
         check("R9", int'(out_valid), 0, 0);
         check("R9", int'(sample), 0, 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      idle(0);

      // R8 single-shot latency, R6 peak; monitor verifies due cycle
      send(QTR);
      idle(5);
      idle(9);

      // cardinal points, R1 R7 R6
      send(0);
      send(2 * QTR);
      send(3 * QTR);
      idle(0);

      // full sweep, ascending then a descending stride, R2 R3 R4 R5
      for (int p = 0; p < NPH; p++) send(p);
      for (int p = NPH - 1; p >= 0; p -= 7) send(p);
      idle(0);

      // R10: hold while idle with changing phase
      @(negedge clk);
      held = sample;
      for (int i = 0; i < 4; i++) begin
         idle(QTR + 37 * i);
         check("R10", int'(sample), int'(held), 0);
         check("R10", int'(out_valid), 0, 0);
      end

      repeat (3) @(negedge clk);
      // R8: every queued result must have appeared
      check("R8", sb.size(), 0, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule